// File: doc/BRIEF.md
# Vector Saturating Rounding Multiply-Accumulate-High Unit

This block is a lane-parallel arithmetic unit for one vector register of `VW` bits (128 by default). It takes a 32-bit instruction word and three vector operands: a multiplicand, a multiplier and an accumulator. A small decoder checks the fixed opcode bits and extracts the lane size, the add/subtract choice and three register indices. The indices go back to the surrounding datapath, which uses them to fetch operands and write the result.

Every lane forms the signed product of its two source elements and doubles it. It adds the accumulator element into the high half, or subtracts the product instead, and rounds at the lane's half point. The lane then keeps the high half and clamps it to the signed range of the lane. No saturation status is recorded anywhere.

A decoded and valid word enters a two-stage pipeline. Its result appears on `result` with `valid_out` exactly two cycles later. A controller state machine tracks which stages hold an operation:

- `PIPE_EMPTY`: no operation is in flight.
- `PIPE_HEAD`: only the capture stage is occupied.
- `PIPE_FULL`: both stages are occupied.
- `PIPE_TAIL`: only the output stage is occupied.

Transitions are made on every clock:

- From `PIPE_EMPTY` or `PIPE_TAIL`, an accepted word moves the controller to `PIPE_HEAD`; otherwise it moves to `PIPE_EMPTY`.
- From `PIPE_HEAD` or `PIPE_FULL`, an accepted word moves it to `PIPE_FULL`; otherwise it moves to `PIPE_TAIL`.

Top module: `vrm_mac_high`

## Requirements
- R1: Size field value 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit. A vector holds VW/w lanes, lane k occupies bits [k*w +: w], and lanes do not affect each other.
- R2: In add mode, each lane of width w returns floor(((acc << (w-1)) + n*m + (1 << (w-2))) / 2^(w-1)), with all values signed.
- R3: In subtract mode, the product n*m is negated before the accumulator term and the rounding constant are added.
- R4: A lane result outside the signed w-bit range is clamped: negative results to the most negative value, positive results to the most positive value.
- R5: 64-bit lanes compute exactly with a wide intermediate. For example, both sources at the most negative value with a zero accumulator give the most positive value.
- R6: Rounding is always applied: an exact half at bit w-2 rounds upward.
- R7: An accepted word (valid_in high and decode_ok high at a clock edge) raises valid_out with its result exactly two clock edges later. Back-to-back words stream at one per cycle.
- R8: decode_ok is high only when all three fixed fields match: instr_word[31:24] = 8'b01000100, instr_word[21] = 0 and instr_word[15:11] = 5'b01110. Bit 10 selects subtract (1) or add (0), and bits [23:22] hold the size. idx_m, idx_n and idx_d show bits [20:16], [9:5] and [4:0].
- R9: A word with decode_ok low is not issued, even when valid_in is high: valid_out stays low in the cycle where its result would appear.
- R10: While and after reset, valid_out is low and result is zero until the first accepted word completes.
- R11: A lane whose multiplicand or multiplier is zero returns its accumulator value unchanged, in both modes and at every size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Instruction word and operands are present |
| instr_word | input | 32 | Instruction word to decode |
| src_n | input | VW | Multiplicand vector |
| src_m | input | VW | Multiplier vector |
| src_acc | input | VW | Accumulator vector |
| decode_ok | output | 1 | Fixed opcode fields match (combinational) |
| idx_n | output | 5 | Multiplicand register index |
| idx_m | output | 5 | Multiplier register index |
| idx_d | output | 5 | Accumulator/destination register index |
| valid_out | output | 1 | result holds a completed operation |
| result | output | VW | Lane results of the operation |

## Verification
The bench uses the most negative operand pair in 8-bit and 64-bit lanes. Here a unit that saturated only on the upper half, or that kept a too-narrow intermediate, would wrap to a negative value instead of clamping positive. An exact-half product in 16-bit lanes exposes a missing or misplaced rounding constant: the lane would return 0 instead of 1. Mismatches in each fixed opcode field and streamed back-to-back words catch a decoder that ignores a field, a word that is issued despite a bad opcode, and a pipeline that drops or duplicates a result. Zero-operand and randomized vectors at all four sizes catch lanes that bleed across boundaries or a subtract path that negates the wrong term.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;

    localparam logic [7:0] OPC_MAJOR = 8'b0100_0100;
    localparam logic [4:0] OPC_MINOR = 5'b01110;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_W32 = 2'd2,
        LANE_D64 = 2'd3
    } lane_size_t;

    typedef enum logic [1:0] {
        PIPE_EMPTY,
        PIPE_HEAD,
        PIPE_FULL,
        PIPE_TAIL
    } pipe_state_t;
endpackage

// File: rtl/vrm_decode.sv
module vrm_decode
    import vrm_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic               ok_o,
    output lane_size_t         size_o,
    output logic               sub_o,
    output logic [IDX_W-1:0]   idx_n_o,
    output logic [IDX_W-1:0]   idx_m_o,
    output logic [IDX_W-1:0]   idx_d_o
);
    always_comb begin
        ok_o    = (word_i[31:24] == OPC_MAJOR) && !word_i[21]
                  && (word_i[15:11] == OPC_MINOR);
        size_o  = lane_size_t'(word_i[23:22]);
        sub_o   = word_i[10];
        idx_m_o = word_i[20:16];
        idx_n_o = word_i[9:5];
        idx_d_o = word_i[4:0];
    end
endmodule

// File: rtl/vrm_lane.sv
module vrm_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] a_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    localparam int EW = 2 * W + 2;
    localparam logic [EW-1:0] RND = {{(EW-1){1'b0}}, 1'b1} << (W - 2);
    localparam logic [W-1:0]  SAT_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  SAT_NEG = {1'b1, {(W-1){1'b0}}};

    logic signed [EW-1:0] ext_n, ext_m, ext_a;
    logic signed [EW-1:0] prod, term, total, shifted;
    logic        [EW-W:0] upper;
    logic                 fits;

    always_comb begin
        ext_n   = {{(EW-W){n_i[W-1]}}, n_i};
        ext_m   = {{(EW-W){m_i[W-1]}}, m_i};
        ext_a   = {{(EW-W){a_i[W-1]}}, a_i};
        prod    = ext_n * ext_m;
        term    = sub_i ? -prod : prod;
        total   = term + (ext_a <<< (W - 1)) + RND;
        shifted = total >>> (W - 1);
        upper   = shifted[EW-1:W-1];
        fits    = (&upper) | ~(|upper);
        if (fits) begin
            y_o = shifted[W-1:0];
        end else if (shifted[EW-1]) begin
            y_o = SAT_NEG;
        end else begin
            y_o = SAT_POS;
        end
    end
endmodule

// File: rtl/vrm_lanes.sv
module vrm_lanes
    import vrm_pkg::*;
#(
    parameter int VW = 128
) (
    input  logic [VW-1:0] n_i,
    input  logic [VW-1:0] m_i,
    input  logic [VW-1:0] a_i,
    input  lane_size_t    size_i,
    input  logic          sub_i,
    output logic [VW-1:0] y_o
);
    localparam int NSIZES = 4;

    logic [VW-1:0] by_size [NSIZES];

    for (genvar gk = 0; gk < NSIZES; gk++) begin : g_width
        localparam int LW = 8 << gk;
        localparam int NL = VW / LW;
        logic [VW-1:0] width_y;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            vrm_lane #(.W(LW)) u_lane (
                .n_i   (n_i[gl*LW +: LW]),
                .m_i   (m_i[gl*LW +: LW]),
                .a_i   (a_i[gl*LW +: LW]),
                .sub_i (sub_i),
                .y_o   (width_y[gl*LW +: LW])
            );
        end
        assign by_size[gk] = width_y;
    end

    always_comb begin
        unique case (size_i)
            LANE_B8:  y_o = by_size[0];
            LANE_H16: y_o = by_size[1];
            LANE_W32: y_o = by_size[2];
            LANE_D64: y_o = by_size[3];
        endcase
    end
endmodule

// File: rtl/vrm_ctrl.sv
module vrm_ctrl
    import vrm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic head_busy_o,
    output logic valid_o
);
    pipe_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PIPE_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            PIPE_EMPTY, PIPE_TAIL: state_nx = accept_i ? PIPE_HEAD : PIPE_EMPTY;
            PIPE_HEAD,  PIPE_FULL: state_nx = accept_i ? PIPE_FULL : PIPE_TAIL;
        endcase
    end

    always_comb begin
        head_busy_o = 1'b0;
        valid_o     = 1'b0;
        unique case (state)
            PIPE_EMPTY: ;
            PIPE_HEAD:  head_busy_o = 1'b1;
            PIPE_FULL:  begin head_busy_o = 1'b1; valid_o = 1'b1; end
            PIPE_TAIL:  valid_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/vrm_mac_high.sv
module vrm_mac_high
    import vrm_pkg::*;
#(
    parameter int VW = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [VW-1:0]      src_n,
    input  logic [VW-1:0]      src_m,
    input  logic [VW-1:0]      src_acc,
    output logic               decode_ok,
    output logic [IDX_W-1:0]   idx_n,
    output logic [IDX_W-1:0]   idx_m,
    output logic [IDX_W-1:0]   idx_d,
    output logic               valid_out,
    output logic [VW-1:0]      result
);
    lane_size_t    dec_size, s1_size;
    logic          dec_sub, s1_sub;
    logic          accept, head_busy;
    logic [VW-1:0] s1_n, s1_m, s1_a, lane_y;

    vrm_decode u_decode (
        .word_i  (instr_word),
        .ok_o    (decode_ok),
        .size_o  (dec_size),
        .sub_o   (dec_sub),
        .idx_n_o (idx_n),
        .idx_m_o (idx_m),
        .idx_d_o (idx_d)
    );

    assign accept = valid_in && decode_ok;

    vrm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .head_busy_o (head_busy),
        .valid_o     (valid_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_n    <= '0;
            s1_m    <= '0;
            s1_a    <= '0;
            s1_size <= LANE_B8;
            s1_sub  <= 1'b0;
        end else if (accept) begin
            s1_n    <= src_n;
            s1_m    <= src_m;
            s1_a    <= src_acc;
            s1_size <= dec_size;
            s1_sub  <= dec_sub;
        end
    end

    vrm_lanes #(.VW(VW)) u_lanes (
        .n_i    (s1_n),
        .m_i    (s1_m),
        .a_i    (s1_a),
        .size_i (s1_size),
        .sub_i  (s1_sub),
        .y_o    (lane_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (head_busy) begin
            result <= lane_y;
        end
    end
endmodule

// File: rtl/vrm_mac_high_chk.sv
module vrm_mac_high_chk #(
    parameter int VW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_in,
    input logic          decode_ok,
    input logic [VW-1:0] src_n,
    input logic [VW-1:0] src_m,
    input logic [VW-1:0] src_acc,
    input logic          valid_out,
    input logic [VW-1:0] result
);
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(valid_in && decode_ok, 2));

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !decode_ok) |=> ##1 !valid_out);

    assert_zero_n_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(src_n, 2) == '0) |-> result == $past(src_acc, 2));

    assert_zero_m_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(src_m, 2) == '0) |-> result == $past(src_acc, 2));

    assert_idle_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out && !$past(valid_out)) |-> $stable(result));
endmodule

bind vrm_mac_high vrm_mac_high_chk #(.VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .decode_ok (decode_ok),
    .src_n     (src_n),
    .src_m     (src_m),
    .src_acc   (src_acc),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/test_vrm_mac_high.sv
module test_vrm_mac_high;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [31:0]   instr_word = '0;
    logic [VW-1:0] src_n = '0, src_m = '0, src_acc = '0;
    logic          decode_ok, valid_out;
    logic [4:0]    idx_n, idx_m, idx_d;
    logic [VW-1:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vrm_mac_high #(.VW(VW)) i_vrm_mac_high (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr_word(instr_word),
        .src_n(src_n), .src_m(src_m), .src_acc(src_acc), .decode_ok(decode_ok),
        .idx_n(idx_n), .idx_m(idx_m), .idx_d(idx_d), .valid_out(valid_out),
        .result(result)
    );

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [1:0] sz, input logic sub,
                                            input logic [4:0] rd, rn, rm);
        return {8'b0100_0100, sz, 1'b0, rm, 5'b01110, sub, rn, rd};
    endfunction

    // Lane model built from the formula of R2/R3/R4.
    function automatic logic [VW-1:0] model(input logic [1:0] sz, input logic sub,
                                            input logic [VW-1:0] n, m, a);
        int w = 8 << sz;
        logic [VW-1:0] out = '0;
        logic [VW-1:0] lmask = (VW'(1) << w) - 1;
        for (int l = 0; l < VW / w; l++) begin
            logic [129:0] tn, tm, ta;
            logic signed [129:0] en, em, ea, p, t, hi, lo;
            tn = 130'(n >> (l * w)) << (130 - w);
            tm = 130'(m >> (l * w)) << (130 - w);
            ta = 130'(a >> (l * w)) << (130 - w);
            en = $signed(tn) >>> (130 - w);
            em = $signed(tm) >>> (130 - w);
            ea = $signed(ta) >>> (130 - w);
            p = en * em;
            if (sub) p = -p;
            t = p + (ea <<< (w - 1)) + (130'sd1 <<< (w - 2));
            t = t >>> (w - 1);
            hi = (130'sd1 <<< (w - 1)) - 130'sd1;
            lo = -(130'sd1 <<< (w - 1));
            if (t > hi) t = hi;
            else if (t < lo) t = lo;
            out = out | ((VW'(t) & lmask) << (l * w));
        end
        return out;
    endfunction

    task automatic run_op(input string req, input logic [1:0] sz, input logic sub,
                          input logic [VW-1:0] n, m, a, input logic [VW-1:0] exp);
        @(negedge clk);
        instr_word = mk_word(sz, sub, 5'd1, 5'd2, 5'd3);
        src_n = n; src_m = m; src_acc = a; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        chk({req, " R7 valid_out low after one edge"}, VW'(valid_out), '0);
        @(negedge clk);
        chk({req, " R7 valid_out after two edges"}, VW'(valid_out), VW'(1));
        chk(req, result, exp);
    endtask

    task automatic t_reset;
        chk("R10 valid_out in reset", VW'(valid_out), '0);
        chk("R10 result in reset", result, '0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 valid_out after reset", VW'(valid_out), '0);
        chk("R10 result after reset", result, '0);
    endtask

    task automatic t_decode;
        instr_word = mk_word(2'd2, 1'b1, 5'd3, 5'd17, 5'd30);
        #1;
        chk("R8 decode_ok on good word", VW'(decode_ok), VW'(1));
        chk("R8 idx_d", VW'(idx_d), VW'(3));
        chk("R8 idx_n", VW'(idx_n), VW'(17));
        chk("R8 idx_m", VW'(idx_m), VW'(30));
        instr_word[21] = 1'b1; #1;
        chk("R8 bit21 set", VW'(decode_ok), '0);
        instr_word = mk_word(2'd0, 1'b0, 5'd0, 5'd0, 5'd0);
        instr_word[31:24] = 8'h45; #1;
        chk("R8 major opcode", VW'(decode_ok), '0);
        instr_word = mk_word(2'd0, 1'b0, 5'd0, 5'd0, 5'd0);
        instr_word[15:11] = 5'b01111; #1;
        chk("R8 minor opcode", VW'(decode_ok), '0);
    endtask

    task automatic t_reject;
        @(negedge clk);
        instr_word = mk_word(2'd0, 1'b0, 5'd0, 5'd0, 5'd0);
        instr_word[21] = 1'b1;
        src_n = {16{8'h05}}; src_m = {16{8'h07}}; src_acc = '0; valid_in = 1'b1;
        @(negedge clk); valid_in = 1'b0;
        chk("R9 no issue edge1", VW'(valid_out), '0);
        @(negedge clk);
        chk("R9 no issue edge2", VW'(valid_out), '0);
    endtask

    task automatic t_sizes;
        logic [VW-1:0] n = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        logic [VW-1:0] m = 128'h7F80_0102_C3D4_55AA_1234_8000_7FFF_F00D;
        logic [VW-1:0] a = 128'h1111_2222_F333_4444_8555_6666_7777_0888;
        for (int s = 0; s < 4; s++) begin
            run_op("R1 R2 add per size", 2'(s), 1'b0, n, m, a, model(2'(s), 1'b0, n, m, a));
        end
        // R1: 8-bit lane 0 only: 64*64=4096, +64 -> 4160>>7=32 (0x20), others zero
        run_op("R1 lane isolation", 2'd0, 1'b0, 128'h40, 128'h40, '0, 128'h20);
    endtask

    task automatic t_sub;
        logic [VW-1:0] n = 128'h3355_77AA_CC11_EE22_4466_8899_BBDD_F001;
        logic [VW-1:0] m = 128'h1F2E_3D4C_5B6A_7988_97A6_B5C4_D3E2_F1F0;
        logic [VW-1:0] a = 128'h0F0F_F0F0_1234_EDCB_7000_9000_0101_FEFE;
        for (int s = 0; s < 4; s++) begin
            run_op("R3 subtract per size", 2'(s), 1'b1, n, m, a, model(2'(s), 1'b1, n, m, a));
        end
        // R3: 16-bit, 0x4000*0x4000 negated, acc 0 -> -0x2000 = 0xE000
        run_op("R3 subtract literal", 2'd1, 1'b1, 128'h4000, 128'h4000, '0, 128'hE000);
    endtask

    task automatic t_sat;
        run_op("R4 8-bit positive clamp", 2'd0, 1'b0, {16{8'h80}}, {16{8'h80}},
               {16{8'h7F}}, {16{8'h7F}});
        run_op("R4 8-bit negative clamp", 2'd0, 1'b1, {16{8'h80}}, {16{8'h80}},
               {16{8'h80}}, {16{8'h80}});
        run_op("R4 32-bit clamp", 2'd2, 1'b0, {4{32'h8000_0000}}, {4{32'h8000_0000}},
               '0, {4{32'h7FFF_FFFF}});
    endtask

    task automatic t_d64;
        run_op("R5 64-bit min*min", 2'd3, 1'b0, {2{64'h8000_0000_0000_0000}},
               {2{64'h8000_0000_0000_0000}}, '0, {2{64'h7FFF_FFFF_FFFF_FFFF}});
        run_op("R5 64-bit sub clamp", 2'd3, 1'b1, {2{64'h8000_0000_0000_0000}},
               {2{64'h8000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}},
               {2{64'h8000_0000_0000_0000}});
        run_op("R5 64-bit exact", 2'd3, 1'b0, {64'h0000_0001_0000_0000, 64'h4000_0000_0000_0000},
               {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0002}, {64'd5, 64'd7},
               {64'd6, 64'd8});
    endtask

    task automatic t_round;
        run_op("R6 exact half rounds up", 2'd1, 1'b0, 128'h80, 128'h80, '0, 128'h1);
        run_op("R6 below half rounds down", 2'd1, 1'b0, 128'h3FFF, 128'h1, '0, 128'h0);
    endtask

    task automatic t_zero;
        for (int s = 0; s < 4; s++) begin
            logic [VW-1:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [VW-1:0] x = {$urandom, $urandom, $urandom, $urandom};
            run_op("R11 zero multiplicand", 2'(s), 1'(s), '0, x, a, a);
            run_op("R11 zero multiplier", 2'(s), 1'(s + 1), x, '0, a, a);
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 24; i++) begin
            logic [VW-1:0] n = {$urandom, $urandom, $urandom, $urandom};
            logic [VW-1:0] m = {$urandom, $urandom, $urandom, $urandom};
            logic [VW-1:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [1:0] sz = 2'(i % 4);
            logic sub = 1'((i / 4) % 2);
            run_op("R2 R3 R4 random", sz, sub, n, m, a, model(sz, sub, n, m, a));
        end
    endtask

    task automatic t_stream;
        logic [VW-1:0] nv [3];
        logic [VW-1:0] mv [3];
        logic [VW-1:0] av [3];
        logic [VW-1:0] ev [3];
        for (int k = 0; k < 3; k++) begin
            nv[k] = {$urandom, $urandom, $urandom, $urandom};
            mv[k] = {$urandom, $urandom, $urandom, $urandom};
            av[k] = {$urandom, $urandom, $urandom, $urandom};
            ev[k] = model(2'(k + 1), 1'(k), nv[k], mv[k], av[k]);
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) chk("R7 stream not yet valid", VW'(valid_out), '0);
            if (i >= 2 && i <= 4) begin
                chk("R7 stream valid", VW'(valid_out), VW'(1));
                chk("R7 stream result", result, ev[i-2]);
            end
            if (i == 5) chk("R7 stream drained", VW'(valid_out), '0);
            if (i < 3) begin
                instr_word = mk_word(2'(i + 1), 1'(i), 5'd4, 5'd5, 5'd6);
                src_n = nv[i]; src_m = mv[i]; src_acc = av[i]; valid_in = 1'b1;
            end else begin
                valid_in = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_decode;
        t_reject;
        t_sizes;
        t_sub;
        t_sat;
        t_d64;
        t_round;
        t_zero;
        t_random;
        t_stream;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule